// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache

This block sits between a processor's instruction fetch port and a slower external memory. It holds 1 KB of instructions, arranged as two ways of 32 sets with four 32-bit words per line. A fetch that hits returns its word on the clock edge after it is accepted. A fetch that misses reads the whole line from memory, one word per acknowledge, in ascending order from the line base. The requested word is returned once the last word of the line has arrived.

A fetch that is flagged as locking pins its line in place, so replacement never evicts it. Replacement inside a set picks an invalid unlocked way first. Otherwise it picks the least recently used unlocked way. When both ways of a set are locked, a miss is still served from memory but nothing is allocated. Two single-cycle commands are provided. One clears every valid bit and leaves the lock bits in place. The other clears every lock bit.

Top module: `icache_lk`

## Requirements
- R1: During and after synchronous reset, `cpu_ready` is 1, `cpu_rvalid` is 0, `mem_req` is 0, and every line is invalid, so the first fetch to any address misses.
- R2: An accepted fetch (`cpu_req` and `cpu_ready` high at a rising edge) that hits raises `cpu_rvalid` for one cycle after that edge, with the stored word on `cpu_rdata`, and issues no memory request.
- R3: On a miss, `cpu_ready` falls and `mem_req` stays high while four words are read. `mem_addr` starts at the line base and steps by 4 after each `mem_ack`, so `mem_addr[3:2]` runs 0,1,2,3. While `mem_ack` is low, `mem_addr` holds its value.
- R4: The cycle after the fourth `mem_ack`, `cpu_rvalid` is 1 and `cpu_rdata` is the requested word. If a way was allocated, every word of that line hits from then on.
- R5: The address splits into byte offset [1:0], word offset [3:2], set index [8:4] and tag [31:9]. Two lines with the same index and different tags can be resident together, one in each way, and at most one way hits.
- R6: On a miss where both ways are valid and unlocked, the least recently used way is replaced. A hit or a fill makes that way the most recently used.
- R7: On a miss, an invalid unlocked way is filled in preference to a valid one. Way 0 is chosen before way 1.
- R8: A fetch with `cpu_lock` high sets the lock bit of the line it hits, or of the line it allocates. A locked line is never chosen for replacement.
- R9: When both ways of the indexed set are locked, a miss reads the line and returns the word but allocates nothing, so the same fetch misses again.
- R10: A one-cycle `inval_all` clears all valid bits and keeps all lock bits.
- R11: A one-cycle `unlock_all` clears all lock bits, after which replacement may again choose the formerly locked ways.
- R12: In any cycle where `inval_all` or `unlock_all` is high, `cpu_ready` is 0 and no fetch is accepted. Both commands take effect only when the cache is not filling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Fetch request, held until accepted |
| cpu_addr | input | 32 | Fetch byte address |
| cpu_lock | input | 1 | Lock the fetched line |
| cpu_ready | output | 1 | Cache can accept a fetch this cycle |
| cpu_rvalid | output | 1 | Fetched word is valid |
| cpu_rdata | output | 32 | Fetched word |
| mem_req | output | 1 | Memory read request during a line fill |
| mem_addr | output | 32 | Memory word address |
| mem_ack | input | 1 | Memory returns `mem_rdata` this cycle |
| mem_rdata | input | 32 | Memory read data |
| inval_all | input | 1 | Clear all valid bits |
| unlock_all | input | 1 | Clear all lock bits |

## Verification
The checker relies on three properties of the inputs:
- the memory raises `mem_ack` only while `mem_req` is high;
- a fetch stays on `cpu_req` until the cache accepts it;
- `inval_all` and `unlock_all` arrive as one-cycle pulses while the cache is idle.

The bench keeps to these rules in the following ways:
- Its memory responder answers only requests it sees, with one stalled beat in every three.
- Its fetch task waits on `cpu_ready` before dropping the request.
- It pulses the commands only between fetches.
- It also presents a fetch during a command pulse, to check that the fetch is held back.

// File: rtl/icl_pkg.sv
package icl_pkg;
  localparam int NWAYS = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } icl_state_e;
endpackage

// File: rtl/icl_way_ram.sv
// One way of instruction storage: one write port, one registered read port.
module icl_way_ram #(
  parameter  int DEPTH = 128,
  parameter  int DW    = 32,
  localparam int RAW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/icl_tag_store.sv
// Tags, valid and lock bits per way, one LRU bit per set, hit and victim logic.
module icl_tag_store import icl_pkg::*; #(
  parameter  int SETS  = 32,
  parameter  int TAG_W = 23,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [NWAYS-1:0] hit_vec,
  output logic             vict_way,
  output logic             vict_ok,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_way,
  input  logic             upd_lock,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             inval,
  input  logic             unlock
);
  logic [NWAYS-1:0] way_vld;
  logic [NWAYS-1:0] way_lck;
  logic [SETS-1:0]  lru_q;   // 1: way 1 is least recently used
  logic             lru_w;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  lck_q;

    always_ff @(posedge clk) begin
      if (fill_en && upd_way == 1'(w)) tag_q[upd_idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
        lck_q <= '0;
      end else begin
        if (inval) vld_q <= '0;
        else if (fill_en && upd_way == 1'(w)) vld_q[upd_idx] <= 1'b1;
        if (unlock) lck_q <= '0;
        else if (upd_en && upd_lock && upd_way == 1'(w)) lck_q[upd_idx] <= 1'b1;
      end
    end

    assign way_vld[w] = vld_q[lk_idx];
    assign way_lck[w] = lck_q[lk_idx];
    assign hit_vec[w] = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  end

  always_ff @(posedge clk) begin
    if (rst) lru_q <= '0;
    else if (upd_en) lru_q[upd_idx] <= ~upd_way;
  end

  assign lru_w = lru_q[lk_idx];

  always_comb begin
    vict_ok  = 1'b1;
    vict_way = lru_w;
    if (!way_lck[0] && !way_vld[0])      vict_way = 1'b0;
    else if (!way_lck[1] && !way_vld[1]) vict_way = 1'b1;
    else if (!way_lck[lru_w])            vict_way = lru_w;
    else if (!way_lck[~lru_w])           vict_way = ~lru_w;
    else                                 vict_ok  = 1'b0;
  end
endmodule

// File: rtl/icache_lk.sv
module icache_lk import icl_pkg::*; #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_lock,
  output logic          cpu_ready,
  output logic          cpu_rvalid,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          inval_all,
  input  logic          unlock_all
);
  localparam int BYTE_W = $clog2(DW / 8);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = AW - IDX_W - OFF_W - BYTE_W;
  localparam int RAW    = IDX_W + OFF_W;

  icl_state_e       state_q;
  logic [TAG_W-1:0] req_tag_q;
  logic [IDX_W-1:0] req_idx_q;
  logic [OFF_W-1:0] req_off_q;
  logic [OFF_W-1:0] beat_q;
  logic             way_q, alloc_q, lock_q;
  logic             rvalid_q, from_ram_q, rd_way_q;
  logic [DW-1:0]    word_q;

  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] lk_idx;
  logic [OFF_W-1:0] lk_off;
  logic             unused_byte;
  logic [NWAYS-1:0] hit_vec;
  logic             hit, hit_way, vict_way, vict_ok;
  logic             idle, accept, fill_beat, fill_last;
  logic             upd_en, fill_en, upd_way, upd_lock;
  logic [IDX_W-1:0] upd_idx;
  logic [DW-1:0]    ram_rd [NWAYS];

  assign lk_tag      = cpu_addr[AW-1 -: TAG_W];
  assign lk_idx      = cpu_addr[BYTE_W+OFF_W +: IDX_W];
  assign lk_off      = cpu_addr[BYTE_W +: OFF_W];
  assign unused_byte = ^cpu_addr[BYTE_W-1:0];

  assign idle      = (state_q == ST_IDLE);
  assign cpu_ready = idle && !inval_all && !unlock_all;
  assign accept    = cpu_req && cpu_ready;
  assign hit       = |hit_vec;
  assign hit_way   = hit_vec[1];
  assign fill_beat = (state_q == ST_FILL) && mem_ack;
  assign fill_last = fill_beat && (&beat_q);

  assign fill_en  = fill_last && alloc_q;
  assign upd_en   = (accept && hit) || fill_en;
  assign upd_idx  = idle ? lk_idx   : req_idx_q;
  assign upd_way  = idle ? hit_way  : way_q;
  assign upd_lock = idle ? cpu_lock : lock_q;

  icl_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .lk_idx   (lk_idx),
    .lk_tag   (lk_tag),
    .hit_vec  (hit_vec),
    .vict_way (vict_way),
    .vict_ok  (vict_ok),
    .upd_en   (upd_en),
    .upd_idx  (upd_idx),
    .upd_way  (upd_way),
    .upd_lock (upd_lock),
    .fill_en  (fill_en),
    .fill_tag (req_tag_q),
    .inval    (inval_all && idle),
    .unlock   (unlock_all && idle)
  );

  for (genvar w = 0; w < NWAYS; w++) begin : g_ram
    icl_way_ram #(.DEPTH(SETS * LINE_WORDS), .DW(DW)) u_ram (
      .clk   (clk),
      .we    (fill_beat && alloc_q && way_q == 1'(w)),
      .waddr (RAW'({req_idx_q, beat_q})),
      .wdata (mem_rdata),
      .raddr (RAW'({lk_idx, lk_off})),
      .rdata (ram_rd[w])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      req_tag_q  <= '0;
      req_idx_q  <= '0;
      req_off_q  <= '0;
      beat_q     <= '0;
      way_q      <= 1'b0;
      alloc_q    <= 1'b0;
      lock_q     <= 1'b0;
      rvalid_q   <= 1'b0;
      from_ram_q <= 1'b0;
      rd_way_q   <= 1'b0;
      word_q     <= '0;
    end else begin
      rvalid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept && hit) begin
            rvalid_q   <= 1'b1;
            from_ram_q <= 1'b1;
            rd_way_q   <= hit_way;
          end else if (accept) begin
            state_q   <= ST_FILL;
            req_tag_q <= lk_tag;
            req_idx_q <= lk_idx;
            req_off_q <= lk_off;
            way_q     <= vict_way;
            alloc_q   <= vict_ok;
            lock_q    <= cpu_lock;
            beat_q    <= '0;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == req_off_q) word_q <= mem_rdata;
            if (&beat_q) begin
              state_q    <= ST_IDLE;
              rvalid_q   <= 1'b1;
              from_ram_q <= 1'b0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = from_ram_q ? ram_rd[rd_way_q] : word_q;
  assign mem_req    = (state_q == ST_FILL);
  assign mem_addr   = {req_tag_q, req_idx_q, beat_q, {BYTE_W{1'b0}}};
endmodule

// File: rtl/icache_lk_chk.sv
module icache_lk_chk #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_req,
  input logic          cpu_ready,
  input logic          cpu_rvalid,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          inval_all,
  input logic          unlock_all,
  input logic [1:0]    hit_vec
);
  localparam int BYTE_W = $clog2(DW / 8);
  localparam int OFF_W  = $clog2(LINE_WORDS);

  logic last_beat;
  assign last_beat = &mem_addr[BYTE_W +: OFF_W];

  // R2: an accepted hit answers on the next cycle without touching memory
  assert_hit_next_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready && |hit_vec) |=> (cpu_rvalid && !mem_req));

  // R3: the fill address steps by one word after each acknowledged beat
  assert_fill_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && !last_beat) |=>
      (mem_req && mem_addr == $past(mem_addr) + AW'(DW / 8)));

  // R3: without an acknowledge the request and address hold
  assert_fill_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R3: no fetch is accepted or answered while a fill is running
  assert_fill_stall_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (!cpu_ready && !cpu_rvalid));

  // R4: the last acknowledged beat ends the fill and answers the fetch
  assert_fill_done_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && last_beat) |=> (cpu_rvalid && !mem_req));

  // R5: at most one way hits
  assert_one_way_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R12: a maintenance command blocks fetch acceptance
  assert_maint_block_R12: assert property (@(posedge clk) disable iff (rst)
    (inval_all || unlock_all) |-> !cpu_ready);
endmodule

bind icache_lk icache_lk_chk #(.AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_req    (cpu_req),
  .cpu_ready  (cpu_ready),
  .cpu_rvalid (cpu_rvalid),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .inval_all  (inval_all),
  .unlock_all (unlock_all),
  .hit_vec    (hit_vec)
);

// File: tb/icache_lk_test.sv
`timescale 1ns/1ps
module icache_lk_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_lock = 1'b0;
  logic        cpu_ready, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        inval_all = 1'b0;
  logic        unlock_all = 1'b0;

  int          n_cmp = 0;
  int          n_bad = 0;
  int          acks = 0;
  logic [1:0]  exp_beat = 2'd0;
  logic [31:0] cur_addr = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  icache_lk uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_lock(cpu_lock),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .inval_all(inval_all), .unlock_all(unlock_all)
  );

  function automatic logic [31:0] mval(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Memory model: answers requests, stalling one beat in three.
  initial begin
    int pace = 0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        chk(mem_addr[3:2] == exp_beat, "R3 beat order", 32'(mem_addr[3:2]), 32'(exp_beat));
        chk(mem_addr[31:4] == cur_addr[31:4], "R3 line base", mem_addr, {cur_addr[31:4], 4'h0});
        if (pace != 1) begin
          mem_ack   = 1'b1;
          mem_rdata = mval(mem_addr);
          acks++;
          exp_beat  = exp_beat + 2'd1;
        end
        pace = (pace + 1) % 3;
      end
    end
  end

  task automatic fetch(input logic [31:0] a, input bit lk, input bit exp_fill, input string rq);
    int n0;
    int w;
    cur_addr = a;
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_lock = lk;
    while (!cpu_ready) @(negedge clk);
    n0 = acks;
    @(negedge clk);
    cpu_req = 1'b0; cpu_lock = 1'b0;
    w = 0;
    while (!cpu_rvalid && w < 60) begin
      @(negedge clk);
      w++;
    end
    chk(cpu_rvalid, rq, 32'(cpu_rvalid), 32'd1);
    chk(cpu_rdata == mval(a), rq, cpu_rdata, mval(a));
    chk((acks - n0) == (exp_fill ? 4 : 0), rq, 32'(acks - n0), exp_fill ? 32'd4 : 32'd0);
    if (!exp_fill) chk(w == 0, rq, 32'(w), 32'd0);
  endtask

  // {address, lock, expect fill}
  localparam logic [33:0] VEC [13] = '{
    {32'h0000_1034, 1'b0, 1'b1},  // R1 first fetch misses, R3 R4 fill
    {32'h0000_1030, 1'b0, 1'b0},  // R4 rest of line hits
    {32'h0000_103C, 1'b0, 1'b0},
    {32'h0000_1238, 1'b0, 1'b1},  // R7 invalid way 1 taken
    {32'h0000_1030, 1'b0, 1'b0},  // R5 both tags resident
    {32'h0000_1234, 1'b0, 1'b0},
    {32'h0000_1430, 1'b0, 1'b1},  // R6 replaces LRU (0x1030)
    {32'h0000_1230, 1'b0, 1'b0},  // R6 MRU line kept
    {32'h0000_1030, 1'b0, 1'b1},  // R6 replaces 0x1430
    {32'h0000_1434, 1'b0, 1'b1},  // R6 replaces 0x1230
    {32'h0000_1038, 1'b0, 1'b0},
    {32'h0000_0040, 1'b0, 1'b1},  // R5 other set
    {32'h0000_004C, 1'b0, 1'b0}
  };

  localparam logic [31:0] LX = 32'h0000_0070;
  localparam logic [31:0] LY = 32'h0000_0270;
  localparam logic [31:0] LZ = 32'h0000_0470;

  initial begin
    repeat (3) @(negedge clk);
    chk(cpu_ready == 1'b0 || cpu_ready == 1'b1, "R1", 32'(cpu_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready, "R1 ready", 32'(cpu_ready), 32'd1);
    chk(!cpu_rvalid, "R1 rvalid", 32'(cpu_rvalid), 32'd0);
    chk(!mem_req, "R1 mem_req", 32'(mem_req), 32'd0);

    for (int i = 0; i < 13; i++)
      fetch(VEC[i][33:2], VEC[i][1], VEC[i][0], VEC[i][0] ? "R3 R4 miss" : "R2 hit");

    // R8 locking
    fetch(LX, 1'b1, 1'b1, "R8 lock fill");
    fetch(LY, 1'b0, 1'b1, "R8 second way");
    fetch(LX, 1'b0, 1'b0, "R8 hit");
    fetch(LY, 1'b0, 1'b0, "R8 hit");
    fetch(LZ, 1'b0, 1'b1, "R8 evicts unlocked");
    fetch(LX, 1'b0, 1'b0, "R8 locked line kept");
    fetch(LY, 1'b0, 1'b1, "R8 refill");
    fetch(LY, 1'b1, 1'b0, "R8 lock on hit");
    // R9 both ways locked
    fetch(LZ, 1'b0, 1'b1, "R9 no allocate");
    fetch(LZ, 1'b0, 1'b1, "R9 misses again");
    fetch(LX, 1'b0, 1'b0, "R9 locked hit");
    fetch(LY, 1'b0, 1'b0, "R9 locked hit");

    // R12 fetch presented during invalidate is held
    @(negedge clk);
    inval_all = 1'b1; cpu_req = 1'b1; cpu_addr = 32'h0000_0040;
    #0.1;
    chk(!cpu_ready, "R12 ready during inval", 32'(cpu_ready), 32'd0);
    @(negedge clk);
    inval_all = 1'b0; cpu_req = 1'b0;
    chk(!cpu_rvalid, "R12 no response", 32'(cpu_rvalid), 32'd0);
    // R10 valid cleared, locks kept
    fetch(LX, 1'b0, 1'b1, "R10 invalidated");
    fetch(LX, 1'b0, 1'b1, "R10 locks kept");
    fetch(32'h0000_0040, 1'b0, 1'b1, "R10 other set invalid");
    fetch(32'h0000_0044, 1'b0, 1'b0, "R10 refilled");

    // R11 unlock
    @(negedge clk);
    unlock_all = 1'b1;
    #0.1;
    chk(!cpu_ready, "R12 ready during unlock", 32'(cpu_ready), 32'd0);
    @(negedge clk);
    unlock_all = 1'b0;
    fetch(LX, 1'b0, 1'b1, "R11 allocates");
    fetch(LX, 1'b0, 1'b0, "R11 hit");
    fetch(LY, 1'b0, 1'b1, "R11 second way");
    fetch(LZ, 1'b0, 1'b1, "R11 replaces old lock");
    fetch(LY, 1'b0, 1'b0, "R11 MRU kept");
    fetch(LX, 1'b0, 1'b1, "R11 evicted");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule